// File: doc/BRIEF.md
# Dual-Master Hardware Semaphore Bank

This block holds a bank of hardware semaphores that a host CPU and a coprocessor share. Each side wraps a critical section that touches a shared resource between an acquire and a release. The bank makes sure that only one of the two is inside that section at any time. Every semaphore is a three-state ownership machine: free, held by the host, or held by the coprocessor.

The host works through a masked register write. Each bit of the write data carries the requested level for one semaphore. The matching bit of a write mask selects which semaphores the access touches. One access can therefore acquire some semaphores and release others, and leave the rest untouched. The coprocessor works through two strobes, acquire and release, that carry a semaphore index. These strobes stand in for its set and clear instructions. The acquire strobe returns a same-cycle flag that tells the coprocessor thread whether it now holds the semaphore.

Both sides can read back a per-semaphore ownership vector. Each vector shows only the semaphores that the reader holds itself. When both sides try to acquire a free semaphore in the same cycle, the coprocessor wins.

Top module: `hwsem_bank`

## Requirements
- R1: A synchronous active-low reset puts every semaphore into the free state, so both ownership vectors read all zeros after reset.
- R2: A host write with the enable high, mask bit n = 1 and data bit n = 1 moves free semaphore n to host-owned. Bit n of data, mask and the readback vectors always refers to semaphore n.
- R3: A host write with the enable high, mask bit n = 1 and data bit n = 0 moves host-owned semaphore n back to free.
- R4: A semaphore whose mask bit is 0 keeps its state whatever its data bit holds. A write presented with the enable low changes nothing.
- R5: An acquire strobe carrying index n moves free semaphore n to coprocessor-owned. A release strobe carrying index n moves coprocessor-owned semaphore n back to free.
- R6: When a host acquire and a coprocessor acquire reach the same free semaphore in the same cycle, the semaphore becomes coprocessor-owned.
- R7: Acquire or release requests from the side that does not hold a locked semaphore are ignored, and the semaphore keeps its owner.
- R8: Readback bit n is 1 on the host vector only while the host holds semaphore n, and 1 on the coprocessor vector only while the coprocessor holds it. The two are never 1 together. Both vectors are registered and show the effect of a request one clock after it is presented.
- R9: The acquire-success flag is combinational and valid in the cycle of the acquire strobe. It is 1 when semaphore n will be coprocessor-owned after the operation, meaning it is free or already coprocessor-owned. It is 0 when the host holds it, and 0 when no acquire strobe is present.
- R10: If the acquire and release strobes are high together, the acquire takes effect and the release is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host write access valid |
| host_wdata | input | N (8) | Requested level per semaphore: 1 acquire, 0 release |
| host_wmask | input | N (8) | Per-semaphore write select |
| cop_set | input | 1 | Coprocessor acquire strobe |
| cop_clr | input | 1 | Coprocessor release strobe |
| cop_idx | input | IDX_W (3) | Semaphore index for the strobes |
| cop_set_ok | output | 1 | Acquire success, same cycle |
| host_own | output | N (8) | Semaphores held by the host |
| cop_own | output | N (8) | Semaphores held by the coprocessor |

## Verification
The assertions check on every cycle that no semaphore is held by both sides. They also check that a held semaphore keeps its owner unless its owner releases it, and that an untouched semaphore does not move. They cover collision priority toward the coprocessor and agreement between the success flag and the next-cycle coprocessor ownership. Only the directed scenarios show the concrete bit positions that a mixed masked write acquires or releases, the reset image, the ignored non-owner requests observed at the readback ports, and the handling of acquire and release strobes presented together.

// File: rtl/hwsem_pkg.sv
// Shared types for the semaphore bank.
// Assumes: two masters only (host and coprocessor).
package hwsem_pkg;
    typedef enum logic [1:0] {
        SEM_FREE  = 2'b00,
        SEM_HOST  = 2'b01,
        SEM_COPRO = 2'b10
    } sem_state_t;
endpackage

// File: rtl/hwsem_host_decode.sv
// Turns a host masked write into per-semaphore acquire and release requests.
// Assumes: data bit n and mask bit n both refer to semaphore n.
module hwsem_host_decode #(
    parameter int N = 8
) (
    input  logic         wr_en,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] wmask,
    output logic [N-1:0] set_vec,
    output logic [N-1:0] clr_vec
);
    // Split the selected bits by their data level.
    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (wr_en) begin
            set_vec = wmask & wdata;
            clr_vec = wmask & ~wdata;
        end
    end
endmodule

// File: rtl/hwsem_cop_decode.sv
// Decodes the coprocessor index strobes into one-hot request vectors.
// Assumes: an acquire strobe overrides a release strobe in the same cycle.
// An index at or above N selects nothing.
module hwsem_cop_decode #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             set_i,
    input  logic             clr_i,
    input  logic [IDX_W-1:0] idx,
    output logic [N-1:0]     set_vec,
    output logic [N-1:0]     clr_vec
);
    for (genvar g = 0; g < N; g++) begin : g_dec
        // One-hot match of the index for semaphore g.
        always_comb begin
            set_vec[g] = set_i && (idx == IDX_W'(g));
            clr_vec[g] = clr_i && !set_i && (idx == IDX_W'(g));
        end
    end
endmodule

// File: rtl/hwsem_cell.sv
// One semaphore: a three-state ownership machine.
// Assumes: requests arrive already decoded. On a free semaphore the
// coprocessor acquire takes priority over the host acquire.
module hwsem_cell
    import hwsem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_set,
    input  logic host_clr,
    input  logic cop_set,
    input  logic cop_clr,
    output logic held_host,
    output logic held_cop,
    output logic cop_can_take
);
    sem_state_t state_q, state_d;

    // Next-state rules: only the owner may release a locked semaphore.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEM_FREE: begin
                if (cop_set)       state_d = SEM_COPRO;
                else if (host_set) state_d = SEM_HOST;
            end
            SEM_HOST:  if (host_clr) state_d = SEM_FREE;
            SEM_COPRO: if (cop_clr)  state_d = SEM_FREE;
            default:   state_d = SEM_FREE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEM_FREE;
        else        state_q <= state_d;
    end

    // Ownership views and the acquire-success term.
    always_comb begin
        held_host    = (state_q == SEM_HOST);
        held_cop     = (state_q == SEM_COPRO);
        cop_can_take = (state_q != SEM_HOST);
    end
endmodule

// File: rtl/hwsem_bank.sv
// Bank of N semaphores shared by a host CPU and a coprocessor.
// Assumes: a single clock domain for both masters. The readback
// vectors are registered state. The acquire flag is combinational.
module hwsem_bank #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr_en,
    input  logic [N-1:0]     host_wdata,
    input  logic [N-1:0]     host_wmask,
    input  logic             cop_set,
    input  logic             cop_clr,
    input  logic [IDX_W-1:0] cop_idx,
    output logic             cop_set_ok,
    output logic [N-1:0]     host_own,
    output logic [N-1:0]     cop_own
);
    logic [N-1:0] h_set, h_clr, c_set, c_clr, can_take;

    hwsem_host_decode #(.N(N)) host_dec_i (
        .wr_en   (host_wr_en),
        .wdata   (host_wdata),
        .wmask   (host_wmask),
        .set_vec (h_set),
        .clr_vec (h_clr)
    );

    hwsem_cop_decode #(.N(N), .IDX_W(IDX_W)) cop_dec_i (
        .set_i   (cop_set),
        .clr_i   (cop_clr),
        .idx     (cop_idx),
        .set_vec (c_set),
        .clr_vec (c_clr)
    );

    for (genvar g = 0; g < N; g++) begin : g_cell
        hwsem_cell cell_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .host_set     (h_set[g]),
            .host_clr     (h_clr[g]),
            .cop_set      (c_set[g]),
            .cop_clr      (c_clr[g]),
            .held_host    (host_own[g]),
            .held_cop     (cop_own[g]),
            .cop_can_take (can_take[g])
        );
    end

    // Success flag: the addressed semaphore is not held by the host.
    always_comb begin
        cop_set_ok = |(c_set & can_take);
    end
endmodule

// File: rtl/hwsem_bank_checker.sv
// Property checker for hwsem_bank, attached by bind.
// Assumes: the same parameters as the bank it watches.
module hwsem_bank_checker #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr_en,
    input logic [N-1:0]     host_wdata,
    input logic [N-1:0]     host_wmask,
    input logic             cop_set,
    input logic             cop_clr,
    input logic [IDX_W-1:0] cop_idx,
    input logic             cop_set_ok,
    input logic [N-1:0]     host_own,
    input logic [N-1:0]     cop_own
);
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (host_own & cop_own) == '0);

    a_r9_no_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cop_set |-> !cop_set_ok);

    for (genvar g = 0; g < N; g++) begin : g_chk
        logic cop_hit;
        assign cop_hit = (cop_idx == IDX_W'(g));

        a_r7_host_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            host_own[g] && !(host_wr_en && host_wmask[g] && !host_wdata[g])
            |=> host_own[g]);

        a_r7_cop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            cop_own[g] && !(cop_clr && !cop_set && cop_hit)
            |=> cop_own[g]);

        a_r6_cop_wins: assert property (@(posedge clk) disable iff (!rst_n)
            !host_own[g] && !cop_own[g] && cop_set && cop_hit
            |=> cop_own[g]);

        a_r4_untouched: assert property (@(posedge clk) disable iff (!rst_n)
            !(host_wr_en && host_wmask[g]) && !((cop_set || cop_clr) && cop_hit)
            |=> $stable(host_own[g]) && $stable(cop_own[g]));

        a_r9_flag_true: assert property (@(posedge clk) disable iff (!rst_n)
            cop_set && cop_hit && cop_set_ok |=> cop_own[g]);

        a_r9_flag_false: assert property (@(posedge clk) disable iff (!rst_n)
            cop_set && cop_hit && !cop_set_ok |=> !cop_own[g]);
    end
endmodule

bind hwsem_bank hwsem_bank_checker #(.N(N), .IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr_en (host_wr_en),
    .host_wdata (host_wdata),
    .host_wmask (host_wmask),
    .cop_set    (cop_set),
    .cop_clr    (cop_clr),
    .cop_idx    (cop_idx),
    .cop_set_ok (cop_set_ok),
    .host_own   (host_own),
    .cop_own    (cop_own)
);

// File: tb/hwsem_bank_tb.sv
module hwsem_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_wr_en;
    logic [7:0] host_wdata, host_wmask;
    logic       cop_set, cop_clr;
    logic [2:0] cop_idx;
    logic       cop_set_ok;
    logic [7:0] host_own, cop_own;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hwsem_bank #(.N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en),
        .host_wdata(host_wdata), .host_wmask(host_wmask),
        .cop_set(cop_set), .cop_clr(cop_clr), .cop_idx(cop_idx),
        .cop_set_ok(cop_set_ok), .host_own(host_own), .cop_own(cop_own)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_own(string req, logic [7:0] eh, logic [7:0] ec);
        check({req, " host_own"}, host_own, eh);
        check({req, " cop_own"}, cop_own, ec);
    endtask

    // One cycle of stimulus; the flag is sampled before the edge and
    // the registered vectors at the following falling edge.
    task automatic step(input logic we, input logic [7:0] d, input logic [7:0] m,
                        input logic s, input logic c, input logic [2:0] i,
                        input logic chk_ok, input logic exp_ok, input string req);
        @(negedge clk);
        host_wr_en = we; host_wdata = d; host_wmask = m;
        cop_set = s; cop_clr = c; cop_idx = i;
        #1;
        if (chk_ok) check({req, " set_ok"}, {7'b0, cop_set_ok}, {7'b0, exp_ok});
        @(negedge clk);
        host_wr_en = 1'b0; host_wdata = '0; host_wmask = '0;
        cop_set = 1'b0; cop_clr = 1'b0; cop_idx = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R1");
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0, "R1");
        check_own("R1 reset", 8'h00, 8'h00);
        rst_n = 1'b1;
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R1");
        check_own("R1 after release", 8'h00, 8'h00);
    endtask

    task automatic t_host;
        step(1'b1, 8'h05, 8'h05, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R2");
        check_own("R2 acquire", 8'h05, 8'h00);
        step(1'b1, 8'hFF, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R4");
        check_own("R4 mask zero", 8'h05, 8'h00);
        step(1'b1, 8'hFA, 8'h01, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R3");
        check_own("R3 release bit0", 8'h04, 8'h00);
        step(1'b0, 8'h00, 8'hFF, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R4");
        check_own("R4 enable low", 8'h04, 8'h00);
        step(1'b1, 8'h00, 8'h04, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R3");
        check_own("R3 release bit2", 8'h00, 8'h00);
    endtask

    task automatic t_cop;
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 3'd3, 1'b1, 1'b1, "R9 free");
        check_own("R5 acquire", 8'h00, 8'h08);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 3'd3, 1'b1, 1'b0, "R9 no strobe");
        check_own("R5 release", 8'h00, 8'h00);
    endtask

    task automatic t_nonowner;
        step(1'b1, 8'h02, 8'h02, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R2");
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 3'd1, 1'b1, 1'b0, "R9 host held");
        check_own("R7 cop set on host", 8'h02, 8'h00);
        step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, "R7");
        check_own("R7 cop clr on host", 8'h02, 8'h00);
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 3'd6, 1'b0, 1'b0, "R5");
        step(1'b1, 8'h00, 8'h40, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R7");
        check_own("R7 host clr on cop", 8'h02, 8'h40);
        step(1'b1, 8'h40, 8'h40, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R7");
        check_own("R7 host set on cop", 8'h02, 8'h40);
        step(1'b1, 8'h00, 8'h02, 1'b0, 1'b1, 3'd6, 1'b0, 1'b0, "R3");
        check_own("R3 R5 cleanup", 8'h00, 8'h00);
    endtask

    task automatic t_collision;
        step(1'b1, 8'h11, 8'h11, 1'b1, 1'b0, 3'd4, 1'b1, 1'b1, "R6");
        check_own("R6 cop wins", 8'h01, 8'h10);
    endtask

    task automatic t_both_strobes;
        step(1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 3'd4, 1'b1, 1'b1, "R9 own");
        check_own("R10 set over clr", 8'h01, 8'h10);
        step(1'b1, 8'h00, 8'h01, 1'b0, 1'b1, 3'd4, 1'b0, 1'b0, "R5");
        check_own("R5 clear all", 8'h00, 8'h00);
    endtask

    task automatic t_full;
        step(1'b1, 8'hFF, 8'h0F, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R2");
        for (int k = 4; k < 8; k++)
            step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 3'(k), 1'b0, 1'b0, "R5");
        check_own("R8 split bank", 8'h0F, 8'hF0);
        check("R8 exclusive", host_own & cop_own, 8'h00);
    endtask

    initial begin
        host_wr_en = 1'b0; host_wdata = '0; host_wmask = '0;
        cop_set = 1'b0; cop_clr = 1'b0; cop_idx = '0; rst_n = 1'b0;
        t_reset();
        t_host();
        t_cop();
        t_nonowner();
        t_collision();
        t_both_strobes();
        t_full();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule